// File: doc/BRIEF.md
# Three-Pass Subranging Conversion Sequencer

This block controls a subranging analog-to-digital converter that builds one 16-bit sample from three 8-bit flash readings. A start request taken while the block is idle places the track/hold in hold. The block then runs three passes. Each pass selects the analog routing, waits a programmable settling time and strobes the flash converter. The block captures the returned code and updates the reference DAC code.

Each pass overlaps the previous one, so the digital side corrects the running result. The first code goes into the top byte of the DAC word. The second code refines it into a 13-bit word. The third code extends that word to the final 16-bit result. After a short recovery interval the track/hold goes back to track mode, the routing returns to its idle setting and a one-cycle done pulse presents the result. All settling times are parameters counted in clock cycles.

Top module: `subrange_seq`

## Requirements
- R1: After reset, and with no conversion started, `hold_o`, `busy_o`, `flash_strobe_o` and `done_o` are 0. `route_o` is 0, and `dac_code_o` and `result_o` are 0.
- R2: When `start_i` is high at a rising edge and `busy_o` is low, `hold_o` and `busy_o` are both high from that edge on. This includes the edge that ends a done cycle, so a request held high starts the next conversion in the cycle right after done.
- R3: A high `start_i` while `busy_o` is high has no effect and is not remembered. Each accepted request gives exactly one conversion with unchanged timing.
- R4: Pass 1 uses route code 0 (attenuated path). `flash_strobe_o` rises SETTLE1_CYC cycles after `hold_o` rises.
- R5: Once the first code c1 is captured, `dac_code_o` equals c1 in bits 15:8 with zeros below. Pass 2 uses route code 1 (single error amplifier residue). Its strobe comes SETTLE2_CYC+1 cycles after the first strobe.
- R6: The second code c2 forms w13 = c1*32 + c2 - 128, limited to 0..8191. After that capture, `dac_code_o` equals w13*8. Pass 3 uses route code 2 (both amplifiers chained). Its strobe comes SETTLE3_CYC+1 cycles after the second. The DAC code does not change while a pass is settling.
- R7: The third code c3 gives the result w13*8 + c3 - 128, limited to 0..65535. `result_o` changes only in a done cycle and then holds that value.
- R8: `done_o` is a one-cycle pulse that comes RECOVER_CYC+1 cycles after the third strobe. In that cycle `hold_o` and `busy_o` are already low and `route_o` is back to 0.
- R9: `flash_strobe_o` is a one-cycle pulse and occurs exactly three times per conversion. The code on `flash_code_i` is taken in the cycle the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-convert request, sampled at each rising edge |
| flash_code_i | input | 8 | Code returned by the flash converter, valid while the strobe is high |
| hold_o | output | 1 | Track/hold command, 1 = hold |
| route_o | output | 2 | Switch/amplifier configuration: 0 attenuate, 1 residue, 2 chained |
| flash_strobe_o | output | 1 | One-cycle flash conversion strobe |
| dac_code_o | output | 16 | Reference DAC code |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| result_o | output | 16 | Final corrected 16-bit result |

## Verification
The bench drives code triples that push both correction stages against their lower and upper limits, plus mid-range triples. A merge that wraps instead of saturating would report a near-full-scale value for an all-zero input, or a small value for an all-ones input. Settling times differ from pass to pass, so a design that swaps counter loads or drops the strobe cycle misses the measured strobe spacing. Requests made in the middle of a conversion would show up as extra hold rises or extra done pulses if they were queued. A request held across a done cycle must restart exactly one cycle later, or the back-to-back test catches the design.

// File: rtl/subrange_pkg.sv
package subrange_pkg;

  typedef enum logic [1:0] {
    ROUTE_ATTEN = 2'd0,
    ROUTE_RESID = 2'd1,
    ROUTE_CHAIN = 2'd2
  } route_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETTLE  = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RECOVER = 2'd3
  } seq_state_t;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/subrange_timer.sv
module subrange_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         zero_o
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load_i) begin
      cnt <= value_i;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero_o = (cnt == '0);

endmodule

// File: rtl/subrange_merge.sv
module subrange_merge #(
  parameter int ACC_W  = 8,
  parameter int CODE_W = 8,
  parameter int SHIFT  = 5,
  parameter int OUT_W  = ACC_W + SHIFT
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [OUT_W-1:0]  word_o
);

  localparam int EXT_W  = OUT_W + 2;
  localparam int OFFSET = 1 << (CODE_W - 1);
  localparam logic signed [EXT_W-1:0] OFF_S = EXT_W'(OFFSET);
  localparam logic signed [EXT_W-1:0] MAX_S = EXT_W'((1 << OUT_W) - 1);

  logic signed [EXT_W-1:0] shifted;
  logic signed [EXT_W-1:0] code_ext;
  logic signed [EXT_W-1:0] sum;

  always_comb begin
    shifted  = $signed({2'b00, acc_i, {SHIFT{1'b0}}});
    code_ext = $signed({{(EXT_W-CODE_W){1'b0}}, code_i});
    sum      = shifted + code_ext - OFF_S;
    if (sum < 0) begin
      word_o = '0;
    end else if (sum > MAX_S) begin
      word_o = '1;
    end else begin
      word_o = sum[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/subrange_seq.sv
module subrange_seq
  import subrange_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SHIFT2      = 5,
  parameter int SHIFT3      = 3,
  parameter int SETTLE1_CYC = 10,
  parameter int SETTLE2_CYC = 10,
  parameter int SETTLE3_CYC = 10,
  parameter int RECOVER_CYC = 5,
  localparam int MID_W = CODE_W + SHIFT2,
  localparam int RES_W = MID_W + SHIFT3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CODE_W-1:0] flash_code_i,
  output logic              hold_o,
  output logic [1:0]        route_o,
  output logic              flash_strobe_o,
  output logic [RES_W-1:0]  dac_code_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o
);

  localparam int unsigned MAX_CYC = max4(SETTLE1_CYC, SETTLE2_CYC,
                                         SETTLE3_CYC, RECOVER_CYC);
  localparam int TMR_W = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [TMR_W-1:0] LD1 = TMR_W'(SETTLE1_CYC - 1);
  localparam logic [TMR_W-1:0] LD2 = TMR_W'(SETTLE2_CYC - 1);
  localparam logic [TMR_W-1:0] LD3 = TMR_W'(SETTLE3_CYC - 1);
  localparam logic [TMR_W-1:0] LDR = TMR_W'(RECOVER_CYC - 1);

  seq_state_t         state;
  logic [1:0]         pass;
  logic [CODE_W-1:0]  code1_q;
  logic [MID_W-1:0]   word13_q;
  logic [RES_W-1:0]   res_pend;
  logic [MID_W-1:0]   w13;
  logic [RES_W-1:0]   w16;
  logic               tmr_load;
  logic [TMR_W-1:0]   tmr_value;
  logic               tmr_zero;

  subrange_merge #(
    .ACC_W (CODE_W),
    .CODE_W(CODE_W),
    .SHIFT (SHIFT2)
  ) u_merge_mid (
    .acc_i (code1_q),
    .code_i(flash_code_i),
    .word_o(w13)
  );

  subrange_merge #(
    .ACC_W (MID_W),
    .CODE_W(CODE_W),
    .SHIFT (SHIFT3)
  ) u_merge_fin (
    .acc_i (word13_q),
    .code_i(flash_code_i),
    .word_o(w16)
  );

  always_comb begin
    tmr_load  = 1'b0;
    tmr_value = LD1;
    if (state == ST_IDLE && start_i) begin
      tmr_load  = 1'b1;
      tmr_value = LD1;
    end else if (state == ST_STROBE) begin
      tmr_load = 1'b1;
      case (pass)
        2'd0:    tmr_value = LD2;
        2'd1:    tmr_value = LD3;
        default: tmr_value = LDR;
      endcase
    end
  end

  subrange_timer #(.W(TMR_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .value_i(tmr_value),
    .zero_o (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      pass           <= 2'd0;
      code1_q        <= '0;
      word13_q       <= '0;
      res_pend       <= '0;
      hold_o         <= 1'b0;
      route_o        <= ROUTE_ATTEN;
      flash_strobe_o <= 1'b0;
      dac_code_o     <= '0;
      busy_o         <= 1'b0;
      done_o         <= 1'b0;
      result_o       <= '0;
    end else begin
      flash_strobe_o <= 1'b0;
      done_o         <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            state      <= ST_SETTLE;
            pass       <= 2'd0;
            hold_o     <= 1'b1;
            busy_o     <= 1'b1;
            route_o    <= ROUTE_ATTEN;
            dac_code_o <= '0;
          end
        end
        ST_SETTLE: begin
          if (tmr_zero) begin
            state          <= ST_STROBE;
            flash_strobe_o <= 1'b1;
          end
        end
        ST_STROBE: begin
          case (pass)
            2'd0: begin
              code1_q    <= flash_code_i;
              dac_code_o <= {flash_code_i, {(RES_W-CODE_W){1'b0}}};
              route_o    <= ROUTE_RESID;
              pass       <= 2'd1;
              state      <= ST_SETTLE;
            end
            2'd1: begin
              word13_q   <= w13;
              dac_code_o <= {w13, {SHIFT3{1'b0}}};
              route_o    <= ROUTE_CHAIN;
              pass       <= 2'd2;
              state      <= ST_SETTLE;
            end
            default: begin
              res_pend <= w16;
              state    <= ST_RECOVER;
            end
          endcase
        end
        ST_RECOVER: begin
          if (tmr_zero) begin
            state    <= ST_IDLE;
            hold_o   <= 1'b0;
            busy_o   <= 1'b0;
            route_o  <= ROUTE_ATTEN;
            done_o   <= 1'b1;
            result_o <= res_pend;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/subrange_seq_chk.sv
module subrange_seq_chk #(
  parameter int CODE_W = 8,
  parameter int RES_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [CODE_W-1:0] flash_code_i,
  input logic              hold_o,
  input logic [1:0]        route_o,
  input logic              flash_strobe_o,
  input logic [RES_W-1:0]  dac_code_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [RES_W-1:0]  result_o
);

  logic [1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || done_o) begin
      pcnt <= 2'd0;
    end else if (flash_strobe_o) begin
      pcnt <= pcnt + 2'd1;
    end
  end

  AST_HOLD_WITH_BUSY: assert property (@(posedge clk) disable iff (rst) hold_o == busy_o); // R2
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst) $rose(busy_o) |-> $past(start_i)); // R2
  AST_STROBE_IN_HOLD: assert property (@(posedge clk) disable iff (rst) flash_strobe_o |-> (hold_o && busy_o)); // R4
  AST_ROUTE_PER_PASS: assert property (@(posedge clk) disable iff (rst) flash_strobe_o |-> (route_o == pcnt)); // R5
  AST_DAC_STILL_SETTLE: assert property (@(posedge clk) disable iff (rst) flash_strobe_o |-> $stable(dac_code_o)); // R6
  AST_RESULT_AT_DONE: assert property (@(posedge clk) disable iff (rst) !$stable(result_o) |-> done_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst) done_o |-> (!busy_o && $past(busy_o) && route_o == 2'd0)); // R8
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst) flash_strobe_o |=> !flash_strobe_o); // R9
  AST_THREE_STROBES: assert property (@(posedge clk) disable iff (rst) done_o |-> (pcnt == 2'd3)); // R9

endmodule

bind subrange_seq subrange_seq_chk #(.CODE_W(CODE_W), .RES_W(RES_W)) u_chk (.*);

// File: tb/test_subrange_seq.sv
`timescale 1ns/1ps
module test_subrange_seq;

  localparam int S1 = 7;
  localparam int S2 = 9;
  localparam int S3 = 4;
  localparam int RC = 3;

  typedef struct {
    int c1;
    int c2;
    int c3;
    int w13;
    int res;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [7:0]  flash_code_i;
  logic        hold_o;
  logic [1:0]  route_o;
  logic        flash_strobe_o;
  logic [15:0] dac_code_o;
  logic        busy_o;
  logic        done_o;
  logic [15:0] result_o;

  item_t q[$];
  int    total = 0;
  int    fails = 0;
  int    pushed = 0;
  int    dones = 0;
  int    hold_rises = 0;
  int    pidx = 0;
  bit    b2b_expect = 1'b0;

  always #4 clk = ~clk;

  subrange_seq #(
    .SETTLE1_CYC(S1),
    .SETTLE2_CYC(S2),
    .SETTLE3_CYC(S3),
    .RECOVER_CYC(RC)
  ) i_subrange_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .flash_code_i(flash_code_i),
    .hold_o(hold_o), .route_o(route_o), .flash_strobe_o(flash_strobe_o),
    .dac_code_o(dac_code_o), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  // flash converter model: returns the current item's code for the pass
  always_comb begin
    flash_code_i = 8'h00;
    if (q.size() > 0) begin
      case (pidx)
        0:       flash_code_i = 8'(q[0].c1);
        1:       flash_code_i = 8'(q[0].c2);
        default: flash_code_i = 8'(q[0].c3);
      endcase
    end
  end

  always @(posedge clk) begin
    if (rst) pidx <= 0;
    else if (flash_strobe_o) pidx <= (pidx == 2) ? 0 : pidx + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lim(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic push_item(input int c1, input int c2, input int c3);
    item_t it;
    it.c1  = c1;
    it.c2  = c2;
    it.c3  = c3;
    it.w13 = lim(c1 * 32 + c2 - 128, 8191);
    it.res = lim(it.w13 * 8 + c3 - 128, 65535);
    q.push_back(it);
    pushed++;
  endtask

  task automatic convert(input int c1, input int c2, input int c3);
    push_item(c1, c2, c3);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (dones != pushed) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  int t = 0;
  int t_hold = 0;
  int t_strobe = 0;
  int t_done = -100;
  int npass = 0;
  bit hold_prev = 1'b0;

  always @(negedge clk) begin
    t++;
    if (!rst) begin
      if (hold_o && !hold_prev) begin
        hold_rises++;
        t_hold = t;
        npass = 0;
        chk(busy_o == 1'b1, "R2", "busy at hold rise", busy_o, 1);
        if (b2b_expect) begin
          chk(t - t_done == 1, "R2", "back-to-back restart gap", t - t_done, 1);
          b2b_expect = 1'b0;
        end
      end
      if (flash_strobe_o && q.size() > 0) begin
        case (npass)
          0: begin
            chk(route_o == 2'd0, "R4", "pass1 route", route_o, 0);
            chk(t - t_hold == S1, "R4", "pass1 settle", t - t_hold, S1);
          end
          1: begin
            chk(route_o == 2'd1, "R5", "pass2 route", route_o, 1);
            chk(int'(dac_code_o) == q[0].c1 * 256, "R5", "dac after pass1",
                dac_code_o, q[0].c1 * 256);
            chk(t - t_strobe == S2 + 1, "R5", "pass2 spacing", t - t_strobe, S2 + 1);
          end
          2: begin
            chk(route_o == 2'd2, "R6", "pass3 route", route_o, 2);
            chk(int'(dac_code_o) == q[0].w13 * 8, "R6", "dac after pass2",
                dac_code_o, q[0].w13 * 8);
            chk(t - t_strobe == S3 + 1, "R6", "pass3 spacing", t - t_strobe, S3 + 1);
          end
          default: chk(1'b0, "R9", "extra strobe", npass + 1, 3);
        endcase
        npass++;
        t_strobe = t;
      end
      if (done_o) begin
        dones++;
        t_done = t;
        chk(npass == 3, "R9", "strobes per conversion", npass, 3);
        chk(t - t_strobe == RC + 1, "R8", "recover time", t - t_strobe, RC + 1);
        chk(!hold_o && !busy_o && route_o == 2'd0, "R8", "track restored",
            {hold_o, busy_o, route_o}, 0);
        if (q.size() > 0) begin
          chk(int'(result_o) == q[0].res, "R7", "result", result_o, q[0].res);
          void'(q.pop_front());
        end else begin
          chk(1'b0, "R3", "unexpected done", dones, pushed);
        end
      end
    end
    hold_prev = hold_o;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!hold_o && !busy_o && !done_o && !flash_strobe_o, "R1", "idle flags",
        {hold_o, busy_o, done_o, flash_strobe_o}, 0);
    chk(route_o == 2'd0 && dac_code_o == 16'd0 && result_o == 16'd0, "R1",
        "idle data", int'(route_o) + int'(dac_code_o) + int'(result_o), 0);

    // mid-range patterns
    convert(8'h80, 8'h80, 8'h80); wait_done();
    convert(8'h12, 8'h9C, 8'h33); wait_done();
    convert(8'hA5, 8'h40, 8'hF0); wait_done();
    // limits: lower clamp both stages, upper clamp both stages
    convert(8'h00, 8'h00, 8'h00); wait_done();
    convert(8'hFF, 8'hFF, 8'hFF); wait_done();
    convert(8'h00, 8'hC8, 8'h00); wait_done();

    // R3 request while busy is ignored
    convert(8'h3C, 8'h7F, 8'h81);
    repeat (4) @(negedge clk);
    start_i = 1'b1;
    repeat (3) @(negedge clk);
    start_i = 1'b0;
    wait_done();
    repeat (30) @(negedge clk);
    chk(busy_o == 1'b0, "R3", "no queued restart", busy_o, 0);
    chk(hold_rises == pushed, "R3", "hold rises", hold_rises, pushed);
    chk(dones == pushed, "R3", "done count", dones, pushed);

    // R2 back-to-back with start held high
    push_item(8'h55, 8'h10, 8'h90);
    push_item(8'hC3, 8'hE0, 8'h05);
    @(negedge clk) start_i = 1'b1;
    while (dones != pushed - 1) @(negedge clk);
    b2b_expect = 1'b1;
    @(negedge clk) start_i = 1'b0;
    wait_done();
    chk(b2b_expect == 1'b0, "R2", "second conversion started", b2b_expect, 0);
    chk(hold_rises == pushed, "R3", "hold rises after back-to-back", hold_rises, pushed);
    chk(int'(result_o) == lim(lim(8'hC3 * 32 + 8'hE0 - 128, 8191) * 8 + 5 - 128, 65535),
        "R7", "result held after done", result_o,
        lim(lim(8'hC3 * 32 + 8'hE0 - 128, 8191) * 8 + 5 - 128, 65535));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule